// File: doc/BRIEF.md
# Five-Step Machine Sequencer with Step Watchdog

This block runs a fixed cycle of five machine steps: fill, cap, label, wrap, and then inspect-and-divert. Each step is held in its own flop, so at most one flop is set. An operator start request begins a cycle from idle. After that, each step hands over to the next when its own completion input goes high. When the final step completes, the machine goes back to idle and waits for the next start.

The safety behaviour is kept close to the step register. The stop-ok input going low clears every step, and so does a power-on clear pulse, and either one overrides any transition. Each step has a watchdog that allows twice the step's expected duration. If a step overruns, the block clears all steps and raises a timeout alarm, and it stays idle until the operator acknowledges. A separate checker counts the active step flops and latches an invariant fault if more than one is set. The level actuator outputs and the one-cycle entry pulses are decoded from the step flops in a separate output stage.

Top module: `step_seq_top`

## Requirements
- R1: While rst_n is low, and after it is released, step_o, act_o, pulse_o, tmo_fault and inv_fault are all zero.
- R2: With no step active, no fault latched, stop_ok high and por_clr low, a high start_req sets the fill step (bit 0 of step_o) at the next clock edge.
- R3: A start_req that arrives while any step is active does not change the step vector.
- R4: When the active step i is 0 to 3 and done_i[i] is high, the next clock edge clears bit i and sets bit i+1 together. Bit order: 0 fill, 1 cap, 2 label, 3 wrap, 4 inspect/divert. Completion inputs of steps that are not active have no effect.
- R5: When the inspect/divert step (bit 4) is active and done_i[4] is high, the next edge leaves no step set.
- R6: When stop_ok is low or por_clr is high, the next edge clears every step. This overrides completion and start inputs.
- R7: act_o[i] is high exactly while step bit i is set.
- R8: pulse_o[i] is high for exactly one cycle, in the first cycle that step bit i is set.
- R9: A step with expected duration E cycles may stay active for at most 2E cycles. If its completion input is still low in the last allowed cycle, the next edge clears all steps and sets tmo_fault. A completion that arrives in that last cycle advances normally.
- R10: While tmo_fault or inv_fault is set, start_req is ignored. A high fault_ack clears both flags and leaves the sequencer idle, and a fresh start_req is then needed.
- R11: inv_fault is set if more than one step flop is ever active at once. In normal operation it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Operator cycle start request |
| stop_ok | input | 1 | Emergency-stop chain healthy (low = stop) |
| por_clr | input | 1 | First-cycle / power-on step clear |
| done_i | input | 5 | Per-step completion inputs |
| fault_ack | input | 1 | Operator fault acknowledge |
| step_o | output | 5 | One-hot step vector |
| act_o | output | 5 | Level actuator drive, one per step |
| pulse_o | output | 5 | Entry pulse, one per step |
| tmo_fault | output | 1 | Step watchdog alarm |
| inv_fault | output | 1 | Step exclusivity alarm |

## Verification
The bench targets the exact watchdog edge. A completion in the last allowed cycle must advance, and one cycle later it must fault. An off-by-one counter would either fault on a legal step or let a stuck step run one cycle too long. The bench also raises emergency-stop while a completion is asserted. A design that lets the transition win would leave a step set and restart mid-cycle. Starts are issued mid-cycle, during a latched fault, and while stop is active. A design that fails to gate any of these would re-enter the fill step on a part that is already part-processed. The bench also checks entry pulses for width and completion inputs of inactive steps for no effect, which exposes a pulse held for a whole step and a transition decoded from the wrong bit.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NSTEP = 5;
  typedef logic [NSTEP-1:0] step_t;
endpackage

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_req,
  input  logic  stop_ok,
  input  logic  por_clr,
  input  step_t done_i,
  input  logic  expire,
  input  logic  fault_any,
  output step_t step_q,
  output step_t step_d
);
  logic  clear_all;
  logic  idle;
  step_t adv;
  step_t shifted;
  step_t launch;

  always_comb begin
    clear_all = !stop_ok || por_clr;
    idle      = (step_q == '0);
    adv       = step_q & done_i;
    shifted   = {adv[NSTEP-2:0], 1'b0};
    launch    = step_t'(idle && start_req);
    if (clear_all || fault_any || expire)
      step_d = '0;
    else
      step_d = (step_q & ~adv) | shifted | launch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  // R6
  clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_ok || por_clr) |=> (step_q == '0));

  // R3
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_q != '0) && start_req && ((step_q & done_i) == '0) && stop_ok
      && !por_clr && !fault_any && !expire) |=> (step_q == $past(step_q)));

  // R5
  last_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q[NSTEP-1] && done_i[NSTEP-1]) |=> (step_q == '0));

  // R11
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_q));
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import seq_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter logic [NSTEP*CNT_W-1:0] LIMS = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  step_t step_q,
  input  step_t step_d,
  input  step_t done_i,
  input  logic  fault_ack,
  output logic  expire,
  output logic  tmo_fault
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_sel;
  logic cnt_en;
  logic tmo_d;

  always_comb begin
    lim_sel = '0;
    for (int i = 0; i < NSTEP; i++)
      if (step_q[i]) lim_sel = lim_sel | LIMS[i*CNT_W +: CNT_W];
  end

  always_comb begin
    expire = (step_q != '0) && ((step_q & done_i) == '0)
             && (cnt_q == lim_sel - CNT_W'(1));
    cnt_en = (step_q != '0) || (cnt_q != '0);
    if (step_d == '0 || step_d != step_q) cnt_d = '0;
    else                                  cnt_d = cnt_q + CNT_W'(1);
    if (expire)         tmo_d = 1'b1;
    else if (fault_ack) tmo_d = 1'b0;
    else                tmo_d = tmo_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tmo_fault <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      tmo_fault <= tmo_d;
    end
  end

  // R9
  expire_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (tmo_fault && step_q == '0));

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ack && !expire) |=> !tmo_fault);
endmodule

// File: rtl/seq_excl.sv
module seq_excl
  import seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_t step_q,
  input  logic  fault_ack,
  output logic  inv_fault
);
  logic [$clog2(NSTEP+1)-1:0] n_act;
  logic multi;
  logic inv_d;

  always_comb begin
    n_act = '0;
    for (int i = 0; i < NSTEP; i++)
      n_act = n_act + {{($clog2(NSTEP+1)-1){1'b0}}, step_q[i]};
    multi = (n_act > 1);
    if (multi)          inv_d = 1'b1;
    else if (fault_ack) inv_d = 1'b0;
    else                inv_d = inv_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_fault <= 1'b0;
    else        inv_fault <= inv_d;
  end

  // R11
  inv_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(step_q) > 1) |=> inv_fault);
endmodule

// File: rtl/seq_outputs.sv
module seq_outputs
  import seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_t step_q,
  output step_t act_o,
  output step_t pulse_o
);
  step_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= step_q;
  end

  always_comb begin
    act_o   = step_q;
    pulse_o = step_q & ~prev_q;
  end

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o != '0) |=> ((pulse_o & $past(pulse_o)) == '0));

  // R7
  pulse_in_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_o & ~act_o) == '0));
endmodule

// File: rtl/step_seq_top.sv
module step_seq_top
  import seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int EXP_FILL  = 8,
  parameter int EXP_CAP   = 6,
  parameter int EXP_LABEL = 5,
  parameter int EXP_WRAP  = 7,
  parameter int EXP_INSP  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       stop_ok,
  input  logic       por_clr,
  input  logic [4:0] done_i,
  input  logic       fault_ack,
  output logic [4:0] step_o,
  output logic [4:0] act_o,
  output logic [4:0] pulse_o,
  output logic       tmo_fault,
  output logic       inv_fault
);
  localparam logic [NSTEP*CNT_W-1:0] LIMS = {
    CNT_W'(2*EXP_INSP), CNT_W'(2*EXP_WRAP), CNT_W'(2*EXP_LABEL),
    CNT_W'(2*EXP_CAP),  CNT_W'(2*EXP_FILL)};

  step_t step_q, step_d;
  logic  expire;
  logic  tmo_w, inv_w;

  seq_core u_core (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_ok(stop_ok),
    .por_clr(por_clr), .done_i(done_i), .expire(expire),
    .fault_any(tmo_w | inv_w), .step_q(step_q), .step_d(step_d));

  seq_watchdog #(.CNT_W(CNT_W), .LIMS(LIMS)) u_wd (
    .clk(clk), .rst_n(rst_n), .step_q(step_q), .step_d(step_d),
    .done_i(done_i), .fault_ack(fault_ack), .expire(expire),
    .tmo_fault(tmo_w));

  seq_excl u_excl (
    .clk(clk), .rst_n(rst_n), .step_q(step_q), .fault_ack(fault_ack),
    .inv_fault(inv_w));

  seq_outputs u_out (
    .clk(clk), .rst_n(rst_n), .step_q(step_q), .act_o(act_o),
    .pulse_o(pulse_o));

  assign step_o    = step_q;
  assign tmo_fault = tmo_w;
  assign inv_fault = inv_w;
endmodule

// File: tb/sim_step_seq_top.sv
module sim_step_seq_top;
  logic       clk = 1'b0;
  logic       rst_n, start_req, stop_ok, por_clr, fault_ack;
  logic [4:0] done_i;
  logic [4:0] step_o, act_o, pulse_o;
  logic       tmo_fault, inv_fault;
  int         n_chk = 0, n_bad = 0;
  bit         ended = 1'b0;

  always #5 clk = ~clk;

  step_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_ok(stop_ok),
    .por_clr(por_clr), .done_i(done_i), .fault_ack(fault_ack),
    .step_o(step_o), .act_o(act_o), .pulse_o(pulse_o),
    .tmo_fault(tmo_fault), .inv_fault(inv_fault));

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    stop_ok = 1'b0; done_i = '0; start_req = 1'b0; tick();
    stop_ok = 1'b1; tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_req = 0; stop_ok = 1; por_clr = 0; fault_ack = 0;
    done_i = '0;
    #23;
    chk("R1 step in reset", 32'(step_o), 0);
    rst_n = 1'b1; tick();
    chk("R1 step after reset", 32'(step_o), 0);
    chk("R1 act after reset", 32'(act_o), 0);
    chk("R1 pulse after reset", 32'(pulse_o), 0);
    chk("R1 faults after reset", {30'd0, tmo_fault, inv_fault}, 0);
  endtask

  task automatic t_full_cycle();
    start_req = 1'b1; tick();
    chk("R2 start sets fill", 32'(step_o), 1);
    chk("R7 act follows fill", 32'(act_o), 1);
    chk("R8 fill entry pulse", 32'(pulse_o), 1);
    start_req = 1'b0; tick();
    chk("R8 pulse lasts one cycle", 32'(pulse_o), 0);
    chk("R7 act held during step", 32'(act_o), 1);
    for (int i = 0; i < 5; i++) begin
      done_i = 5'(1 << i); tick();
      if (i < 4) begin
        chk("R4 advance to next step", 32'(step_o), 32'(1 << (i + 1)));
        chk("R8 entry pulse on next step", 32'(pulse_o), 32'(1 << (i + 1)));
      end else begin
        chk("R5 last step returns idle", 32'(step_o), 0);
        chk("R7 actuators off in idle", 32'(act_o), 0);
      end
      done_i = '0;
    end
    chk("R11 no invariant fault", 32'(inv_fault), 0);
  endtask

  task automatic t_ignored();
    start_req = 1'b1; tick(); start_req = 1'b0;
    done_i = 5'b00100; tick(); done_i = '0;
    chk("R4 inactive done ignored", 32'(step_o), 1);
    done_i = 5'b00001; tick(); done_i = '0;
    chk("R4 fill to cap", 32'(step_o), 2);
    start_req = 1'b1; tick(); start_req = 1'b0;
    chk("R3 mid-cycle start ignored", 32'(step_o), 2);
    chk("R3 no fill pulse on ignored start", 32'(pulse_o), 0);
    go_idle();
  endtask

  task automatic t_estop();
    start_req = 1'b1; tick(); start_req = 1'b0;
    done_i = 5'b00001; tick();
    done_i = 5'b00010; tick();
    chk("R4 reached label", 32'(step_o), 4);
    done_i = 5'b00100; stop_ok = 1'b0; tick(); done_i = '0;
    chk("R6 stop beats completion", 32'(step_o), 0);
    chk("R6 actuators dropped", 32'(act_o), 0);
    start_req = 1'b1; tick();
    chk("R6 start ignored while stopped", 32'(step_o), 0);
    stop_ok = 1'b1; tick(); start_req = 1'b0;
    chk("R2 restart from fill", 32'(step_o), 1);
    done_i = 5'b00001; por_clr = 1'b1; tick(); done_i = '0; por_clr = 1'b0;
    chk("R6 power-on clear", 32'(step_o), 0);
  endtask

  task automatic t_timeout();
    start_req = 1'b1; tick(); start_req = 1'b0;
    for (int k = 0; k < 15; k++) tick();
    chk("R9 fill alive at limit", 32'(step_o), 1);
    chk("R9 no fault before limit", 32'(tmo_fault), 0);
    tick();
    chk("R9 overrun clears steps", 32'(step_o), 0);
    chk("R9 overrun raises fault", 32'(tmo_fault), 1);
    start_req = 1'b1; tick(); start_req = 1'b0;
    chk("R10 start ignored in fault", 32'(step_o), 0);
    fault_ack = 1'b1; tick(); fault_ack = 1'b0;
    chk("R10 ack clears fault", 32'(tmo_fault), 0);
    chk("R10 idle after ack", 32'(step_o), 0);
    start_req = 1'b1; tick(); start_req = 1'b0;
    chk("R10 fresh start after ack", 32'(step_o), 1);
    go_idle();
  endtask

  task automatic t_late_done();
    start_req = 1'b1; tick(); start_req = 1'b0;
    done_i = 5'b00001; tick(); done_i = '0;
    for (int k = 0; k < 11; k++) tick();
    chk("R9 cap alive in last cycle", 32'(step_o), 2);
    done_i = 5'b00010; tick(); done_i = '0;
    chk("R9 last-cycle done advances", 32'(step_o), 4);
    chk("R9 no fault on last-cycle done", 32'(tmo_fault), 0);
    chk("R11 invariant still clean", 32'(inv_fault), 0);
    go_idle();
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_cycle();
    t_ignored();
    t_estop();
    t_timeout();
    t_late_done();
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule